// File: doc/BRIEF.md
# Programmable Two-Level Interrupt Router

This block gathers up to 32 level-sensitive peripheral request lines and up to seven fixed core events, and names the single most urgent pending event as a level number from 0 to 15. Each peripheral line has a peripheral ID and a 4-bit routing field. The field picks one of the nine general-purpose levels, 7 to 15, as that line's destination. Several physical sources that share one ID are ORed together before they reach the ID's input pin.

Each level has a pending bit. The bit is set by a rising edge of that level's combined request, or by a software write. It stays set until an acknowledge for that level arrives. A mask register hides levels 5 to 15 from the output without clearing their pending bits. The result is registered. The output is the lowest-numbered level that is pending and not masked, together with a valid flag.

A simple word-addressed bus reads and writes the routing fields, the mask and the software-raise register. Reads from the software-raise address return the pending vector.

Top module: `irq_router`

## Requirements
- R1: After reset, `top_valid` is 0, the pending vector reads 0, the mask reads 0, and every routing field holds its default value.
- R2: Default routing by peripheral ID:
  - IDs 0-2 go to level 7.
  - ID 3 goes to level 8.
  - IDs 4-7 go to level 9.
  - IDs 8-14 go to level 10.
  - IDs 15-18 go to level 11.
  - IDs 19-28 go to level 12.
  - IDs 29-31 go to level 13.
  - No ID routes to level 14 or 15 by default.
- R3: Routing field layout and encoding:
  - Bus word w (address 0 to 3) holds the field of ID 8w+j in bits [4j+3:4j].
  - A field value f selects level 7+f. Any value above 8 selects level 15.
  - Reads return the stored field value unchanged.
- R4: When valid, `top_level` is the lowest-numbered level that is pending and not masked. `top_valid` is 0 when no such level exists.
- R5: A level's pending bit sets on a 0-to-1 transition of that level's request. A request that is held high does not set the bit again after an acknowledge until the request falls and rises again.
- R6: Asserting `ack_valid` with `ack_level` = n clears pending bit n. If a new set of the same level arrives in that cycle, the set wins.
- R7: Mask register (address 4):
  - Bit n = 1 hides level n, for n = 5 to 15.
  - Bits 0 to 4 read 0 and have no effect.
  - A hidden level stays pending and is reported once its mask bit is cleared.
- R8: Software-raise register (address 5):
  - Writing a 1 to bit n, for n = 7 to 15, sets pending bit n.
  - Write bits 0 to 6 are ignored.
  - A read of this address returns the 16-bit pending vector.
- R9: Sources that share a level are ORed, so a second source rising while another holds that level high creates no new pending event. Core events drive levels 0, 1, 2, 3, 5 and 6 from `core_evt` bits of the same number. Bit 4 is ignored, and level 4 is never pending or reported.
- R10: The pending bit sets one clock after a request edge, and the output register updates one clock after that. A peripheral edge driven before clock edge k therefore appears after edge k+1 and not after edge k.
- R11: Rewriting a routing field moves a source at once. If the source is held high and its new level had no active request, the new level becomes pending. It is reported three clock edges after the bus write is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | 32 | Peripheral request lines, indexed by peripheral ID |
| core_evt | input | 7 | Core event requests for levels 0 to 6 (bit 4 unused) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: 0-3 routing, 4 mask, 5 software raise / pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| top_valid | output | 1 | A pending, unmasked level exists |
| top_level | output | 4 | Lowest-numbered pending, unmasked level |

## Verification
The hardest case to reach from the ports is a pending event created by reprogramming rather than by a pin edge. A source must already be high and acknowledged at its old level, so that no edge remains to be seen. A routing write then moves it to an idle level, and the new level pends on the remapped request alone. The stimulus reaches this state by raising ID 20, acknowledging level 12 while the line stays high, and rewriting its field twice: once to level 14, then to a saturating code that selects level 15. A separate sequence drives an acknowledge and a fresh edge on the same level in the same cycle to check that the set wins.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int LVL_W    = 4;
  localparam int NUM_LVL  = 16;
  localparam int GP_FIRST = 7;
  localparam int GP_COUNT = 9;
  localparam int NUM_CORE = 7;

  // levels that the mask register may hide (5..15)
  localparam logic [NUM_LVL-1:0] MASKABLE_BITS = 16'hFFE0;
  // levels that the software-raise register may set (7..15)
  localparam logic [NUM_LVL-1:0] SW_BITS       = 16'hFF80;
  // core event inputs that are wired to a level (4 is reserved)
  localparam logic [NUM_CORE-1:0] CORE_USED    = 7'b110_1111;

  // routing field -> absolute level, codes above 8 saturate at 15
  function automatic logic [LVL_W-1:0] field_to_level(input logic [3:0] f);
    if (f > 4'd8) return 4'd15;
    return 4'(f + 4'd7);
  endfunction

  // reset value of the routing field of peripheral ID id
  function automatic logic [3:0] default_field(input int id);
    if (id <= 2)  return 4'd0;
    if (id == 3)  return 4'd1;
    if (id <= 7)  return 4'd2;
    if (id <= 14) return 4'd3;
    if (id <= 18) return 4'd4;
    if (id <= 28) return 4'd5;
    return 4'd6;
  endfunction

  // {found, index of lowest set bit}
  function automatic logic [LVL_W:0] lowest_set(input logic [NUM_LVL-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LVL_W'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_LVL-1:0]         pend_vec,
  output logic [NUM_SRC*FIELD_W-1:0] fields_o,
  output logic [NUM_LVL-1:0]         block_o,
  output logic [NUM_LVL-1:0]         sw_set_o,
  output logic [DATA_W-1:0]          rdata
);

  localparam int FPW       = DATA_W / FIELD_W;
  localparam int NUM_WORDS = NUM_SRC / FPW;
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] SWR_ADDR  = ADDR_W'(NUM_WORDS + 1);

  logic [NUM_LVL-1:0] blk_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fld
    localparam int WIDX = i / FPW;
    localparam int FOFF = (i % FPW) * FIELD_W;
    logic [FIELD_W-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fld_q <= FIELD_W'(default_field(i));
      else if (wr_en && addr == ADDR_W'(WIDX))
        fld_q <= wdata[FOFF +: FIELD_W];
    end
    assign fields_o[i*FIELD_W +: FIELD_W] = fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blk_q <= '0;
    else if (wr_en && addr == MASK_ADDR)
      blk_q <= wdata[NUM_LVL-1:0] & MASKABLE_BITS;
  end

  assign block_o  = blk_q;
  assign sw_set_o = (wr_en && addr == SWR_ADDR) ? (wdata[NUM_LVL-1:0] & SW_BITS) : '0;

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(w)) rdata = fields_o[w*DATA_W +: DATA_W];
    end
    if (addr == MASK_ADDR) rdata = {{(DATA_W-NUM_LVL){1'b0}}, blk_q};
    if (addr == SWR_ADDR)  rdata = {{(DATA_W-NUM_LVL){1'b0}}, pend_vec};
  end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 4
) (
  input  logic [NUM_SRC-1:0]         src_irq,
  input  logic [NUM_SRC*FIELD_W-1:0] fields,
  input  logic [NUM_CORE-1:0]        core_evt,
  output logic [NUM_LVL-1:0]         lvl_req
);

  logic [NUM_LVL-1:0] gp_req;

  // each active source lights its destination level; shared levels OR together
  always_comb begin
    gp_req = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_irq[i]) gp_req[field_to_level(4'(fields[i*FIELD_W +: FIELD_W]))] = 1'b1;
    end
  end

  assign lvl_req = gp_req | {{(NUM_LVL-NUM_CORE){1'b0}}, core_evt & CORE_USED};

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] lvl_req,
  input  logic [NUM_LVL-1:0] sw_set,
  input  logic               ack_valid,
  input  logic [LVL_W-1:0]   ack_level,
  output logic [NUM_LVL-1:0] pend_q,
  output logic [NUM_LVL-1:0] set_vec
);

  logic [NUM_LVL-1:0] req_q;
  logic [NUM_LVL-1:0] clr_vec;
  logic [NUM_LVL-1:0] req_rise;

  assign req_rise = lvl_req & ~req_q;
  assign set_vec  = req_rise | sw_set;
  assign clr_vec  = ack_valid ? (NUM_LVL'(1) << ack_level) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= lvl_req;
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !set_vec[ack_level]) |=> !pend_q[$past(ack_level)]); // R6

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] pend,
  input  logic [NUM_LVL-1:0] block,
  output logic               top_valid,
  output logic [LVL_W-1:0]   top_level
);

  logic [NUM_LVL-1:0] eligible;
  logic [LVL_W:0]     pick;

  assign eligible = pend & ~block;
  assign pick     = lowest_set(eligible);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_valid <= 1'b0;
      top_level <= '0;
    end else begin
      top_valid <= pick[LVL_W];
      top_level <= pick[LVL_W-1:0];
    end
  end

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (top_valid == $past(|eligible))); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (($past(eligible) & ((NUM_LVL'(1) << top_level) - NUM_LVL'(1))) == '0)); // R4

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> ((($past(block) >> top_level) & NUM_LVL'(1)) == '0)); // R7

  AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (top_level != 4'd4)); // R9

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  periph_irq,
  input  logic [NUM_CORE-1:0] core_evt,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ack_valid,
  input  logic [LVL_W-1:0]    ack_level,
  output logic                top_valid,
  output logic [LVL_W-1:0]    top_level
);

  logic [NUM_SRC*FIELD_W-1:0] fields;
  logic [NUM_LVL-1:0]         block_vec;
  logic [NUM_LVL-1:0]         sw_set;
  logic [NUM_LVL-1:0]         lvl_req;
  logic [NUM_LVL-1:0]         pend_vec;
  logic [NUM_LVL-1:0]         set_vec;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pend_vec(pend_vec), .fields_o(fields), .block_o(block_vec),
    .sw_set_o(sw_set), .rdata(bus_rdata)
  );

  irq_level_map #(.NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W)) u_map (
    .src_irq(periph_irq), .fields(fields), .core_evt(core_evt), .lvl_req(lvl_req)
  );

  irq_pend_track u_pend (
    .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .sw_set(sw_set),
    .ack_valid(ack_valid), .ack_level(ack_level), .pend_q(pend_vec), .set_vec(set_vec)
  );

  irq_prio_sel u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend_vec), .block(block_vec),
    .top_valid(top_valid), .top_level(top_level)
  );

  AST_PEND_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_vec[9])) |-> $past(lvl_req[9] | sw_set[9])); // R5

endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] periph_irq;
  logic [6:0]  core_evt;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ack_valid;
  logic [3:0]  ack_level;
  logic        top_valid;
  logic [3:0]  top_level;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .core_evt(core_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_level(ack_level), .top_valid(top_valid), .top_level(top_level)
  );

  typedef struct {
    int         at;
    logic       v;
    logic [3:0] l;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_item;
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop due expectations and compare to the outputs
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      mon_item = sb_q.pop_front();
      checks++;
      if (mon_item.at != cyc || top_valid !== mon_item.v ||
          (mon_item.v && top_level !== mon_item.l)) begin
        errors++;
        $display("FAIL %s: cycle %0d valid=%0b level=%0d, expected valid=%0b level=%0d",
                 mon_item.tag, cyc, top_valid, top_level, mon_item.v, mon_item.l);
      end
    end
  end

  // independent statement of the default routing
  function automatic int def_level(input int id);
    if (id < 3)   return 7;
    if (id < 4)   return 8;
    if (id < 8)   return 9;
    if (id < 15)  return 10;
    if (id < 19)  return 11;
    if (id < 29)  return 12;
    return 13;
  endfunction

  function automatic logic [31:0] def_word(input int w);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) r[4*j +: 4] = 4'(def_level(8*w + j) - 7);
    return r;
  endfunction

  task automatic expect_top(input int dly, input logic v, input logic [3:0] l, input string tag);
    exp_t e;
    e.at = cyc + dly; e.v = v; e.l = l; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv_irq(input int id, input logic val, input logic v, input logic [3:0] l,
                         input string tag);
    @(negedge clk);
    periph_irq[id] = val;
    expect_top(2, v, l, tag);
    idle(3);
  endtask

  task automatic drv_core(input int b, input logic val, input logic v, input logic [3:0] l,
                          input string tag);
    @(negedge clk);
    core_evt[b] = val;
    expect_top(2, v, l, tag);
    idle(3);
  endtask

  task automatic drv_ack(input logic [3:0] lvl, input logic v, input logic [3:0] l,
                         input string tag);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_level = lvl;
    expect_top(2, v, l, tag);
    @(negedge clk);
    ack_valid = 1'b0;
    idle(2);
  endtask

  task automatic drv_write(input logic [2:0] a, input logic [31:0] d, input int dly,
                           input logic v, input logic [3:0] l, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    expect_top(dly, v, l, tag);
    @(negedge clk);
    bus_wr = 1'b0;
    idle(3);
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr %0d got %h, expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w2, w2_new;
    rst_n = 1'b0; periph_irq = '0; core_evt = '0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; ack_valid = 1'b0; ack_level = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R2/R3 default fields
    checks++;
    if (top_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: top_valid=%0b, expected 0", top_valid);
    end
    for (int w = 0; w < 4; w++) rd_check(3'(w), def_word(w), "R2");
    rd_check(3'd4, 32'h0, "R1");
    rd_check(3'd5, 32'h0, "R1");

    // R10: nothing after one edge, result after two
    @(negedge clk);
    periph_irq[25] = 1'b1;
    expect_top(1, 1'b0, 4'd0, "R10");
    expect_top(2, 1'b1, 4'd12, "R10");
    idle(3);
    drv_ack(4'd12, 1'b0, 4'd0, "R6");
    drv_irq(25, 1'b0, 1'b0, 4'd0, "R5");

    // R2/R4/R5/R6 basic routing, priority and acknowledge
    drv_irq(20, 1'b1, 1'b1, 4'd12, "R2");
    drv_irq(3, 1'b1, 1'b1, 4'd8, "R4");
    drv_ack(4'd8, 1'b1, 4'd12, "R6");
    expect_top(1, 1'b1, 4'd12, "R5");
    idle(3);
    drv_irq(3, 1'b0, 1'b1, 4'd12, "R5");
    drv_ack(4'd12, 1'b0, 4'd0, "R6");
    drv_irq(20, 1'b0, 1'b0, 4'd0, "R5");

    // R9 shared level ORing
    drv_irq(1, 1'b1, 1'b1, 4'd7, "R2");
    drv_ack(4'd7, 1'b0, 4'd0, "R6");
    drv_irq(2, 1'b1, 1'b0, 4'd0, "R9");
    rd_check(3'd5, 32'h0, "R9");
    drv_irq(1, 1'b0, 1'b0, 4'd0, "R9");
    drv_irq(2, 1'b0, 1'b0, 4'd0, "R9");
    drv_irq(2, 1'b1, 1'b1, 4'd7, "R9");
    drv_ack(4'd7, 1'b0, 4'd0, "R6");
    drv_irq(2, 1'b0, 1'b0, 4'd0, "R9");

    // R9 core events, reserved bit
    drv_core(4, 1'b1, 1'b0, 4'd0, "R9");
    rd_check(3'd5, 32'h0, "R9");
    drv_core(6, 1'b1, 1'b1, 4'd6, "R4");
    drv_core(0, 1'b1, 1'b1, 4'd0, "R4");
    drv_ack(4'd0, 1'b1, 4'd6, "R6");
    drv_ack(4'd6, 1'b0, 4'd0, "R6");
    drv_core(0, 1'b0, 1'b0, 4'd0, "R9");
    drv_core(4, 1'b0, 1'b0, 4'd0, "R9");
    drv_core(6, 1'b0, 1'b0, 4'd0, "R9");

    // R7 mask
    drv_write(3'd4, 32'h0000_020F, 2, 1'b0, 4'd0, "R7");
    rd_check(3'd4, 32'h0000_0200, "R7");
    drv_irq(5, 1'b1, 1'b0, 4'd0, "R7");
    rd_check(3'd5, 32'h0000_0200, "R7");
    drv_write(3'd4, 32'h0, 2, 1'b1, 4'd9, "R7");
    drv_ack(4'd9, 1'b0, 4'd0, "R6");
    drv_irq(5, 1'b0, 1'b0, 4'd0, "R7");
    drv_write(3'd4, 32'h0000_FFFF, 2, 1'b0, 4'd0, "R7");
    rd_check(3'd4, 32'h0000_FFE0, "R7");
    drv_core(2, 1'b1, 1'b1, 4'd2, "R7");
    drv_irq(0, 1'b1, 1'b1, 4'd2, "R7");
    drv_ack(4'd2, 1'b0, 4'd0, "R7");
    drv_write(3'd4, 32'h0, 2, 1'b1, 4'd7, "R7");
    drv_ack(4'd7, 1'b0, 4'd0, "R6");
    drv_core(2, 1'b0, 1'b0, 4'd0, "R7");
    drv_irq(0, 1'b0, 1'b0, 4'd0, "R7");

    // R8 software raise
    drv_write(3'd5, 32'h0000_C07F, 2, 1'b1, 4'd14, "R8");
    rd_check(3'd5, 32'h0000_C000, "R8");
    drv_ack(4'd14, 1'b1, 4'd15, "R8");
    drv_ack(4'd15, 1'b0, 4'd0, "R8");

    // R11 remap of a held source, R3 saturation
    drv_irq(20, 1'b1, 1'b1, 4'd12, "R11");
    drv_ack(4'd12, 1'b0, 4'd0, "R11");
    w2     = def_word(2);
    w2_new = (w2 & ~(32'hF << 16)) | (32'h7 << 16);
    drv_write(3'd2, w2_new, 3, 1'b1, 4'd14, "R11");
    rd_check(3'd2, w2_new, "R3");
    w2_new = (w2 & ~(32'hF << 16)) | (32'hC << 16);
    drv_write(3'd2, w2_new, 3, 1'b1, 4'd14, "R3");
    rd_check(3'd2, w2_new, "R3");
    drv_ack(4'd14, 1'b1, 4'd15, "R3");
    drv_ack(4'd15, 1'b0, 4'd0, "R3");
    drv_irq(20, 1'b0, 1'b0, 4'd0, "R11");
    drv_write(3'd2, w2, 3, 1'b0, 4'd0, "R3");

    // R6 acknowledge and new edge in the same cycle: set wins
    @(negedge clk);
    periph_irq[8] = 1'b1;
    ack_valid = 1'b1;
    ack_level = 4'd10;
    expect_top(2, 1'b1, 4'd10, "R6");
    @(negedge clk);
    ack_valid = 1'b0;
    idle(3);
    drv_ack(4'd10, 1'b0, 4'd0, "R6");
    drv_irq(8, 1'b0, 1'b0, 4'd0, "R5");

    idle(5);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule